// File: doc/BRIEF.md
# Four-Stage Shift Register with J-K Head Stage

This block is a small register of `WIDTH` stages (four by default) that does one of two things on every rising clock edge, chosen by a single mode input. In load mode every stage captures its own bit of a parallel data word. In shift mode every stage takes the old value of the stage before it, so data moves from stage 0 toward the last stage. The new value of stage 0 comes from a pair of serial inputs, `j_in` and the inverted-sense `kbar_in`. These let the first stage clear, set, hold or toggle while the rest of the chain shifts.

An active-low clear acts at once, without waiting for a clock, and wins over both modes. The outputs are the stage values and the complement of the last stage. Apart from the clear, every change of state happens at a rising clock edge. No data input reaches an output without passing through a register.

Top module: `sr_jk_shifter`

## Requirements
- R1: While `clr_n` is 0, every bit of `q` is 0. It goes to 0 as soon as `clr_n` falls, with no clock edge needed, and stays 0 across clock edges in either mode.
- R2: At a rising edge with `clr_n`=1 and `shift_nload`=0 (load), `q` takes the value of `par_d`. `j_in` and `kbar_in` have no effect on that edge.
- R3: At a rising edge with `clr_n`=1 and `shift_nload`=1 (shift), `q[i]` takes the old `q[i-1]` for every i from 1 to WIDTH-1. `par_d` has no effect on that edge.
- R4: In shift mode with `j_in`=0 and `kbar_in`=0, `q[0]` becomes 0.
- R5: In shift mode with `j_in`=1 and `kbar_in`=1, `q[0]` becomes 1.
- R6: In shift mode with `j_in`=0 and `kbar_in`=1, `q[0]` keeps its old value.
- R7: In shift mode with `j_in`=1 and `kbar_in`=0, `q[0]` becomes the inverse of its old value.
- R8: `q_last_n` is always the complement of `q[WIDTH-1]`.
- R9: With `clr_n`=1 and no rising clock edge, `q` holds its value whatever the data and control inputs do.
- R10: After `clr_n` returns to 1, the first rising edge performs a normal load or shift, starting from the all-zero state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low; forces all stages to 0 |
| shift_nload | input | 1 | Mode select: 0 = parallel load, 1 = shift toward the last stage |
| j_in | input | 1 | Serial J input to stage 0 (shift mode) |
| kbar_in | input | 1 | Serial inverted-K input to stage 0 (shift mode) |
| par_d | input | WIDTH | Parallel data word, bit i goes to stage i |
| q | output | WIDTH | Stage values, bit 0 is the first stage |
| q_last_n | output | 1 | Complement of the last stage |

## Verification
The hardest case to reach is a clear that falls between clock edges. The bench has to show that `q` goes to zero with no edge at all, that the zero survives an edge that would otherwise load a non-zero word, and that the first edge after release starts again from zero. Directed sequences drop `clr_n` in the middle of the low clock phase and probe `q` before the next edge. Random runs also fire clears now and then in the middle of shift traffic. The toggle case can only be seen by tracking stage 0 over several shifts in a row, so the stimulus holds the J-K inputs steady for runs of edges.

// File: rtl/sr_jk_pkg.sv
package sr_jk_pkg;

    localparam int unsigned SR_WIDTH_DEF = 4;

    // Mode selected by the shift/load input
    typedef enum logic {
        CTL_LOAD  = 1'b0,
        CTL_SHIFT = 1'b1
    } ctl_mode_e;

    // What the head stage does in shift mode, coded as {j, kbar}
    typedef enum logic [1:0] {
        HEAD_CLR  = 2'b00,
        HEAD_HOLD = 2'b01,
        HEAD_TGL  = 2'b10,
        HEAD_SET  = 2'b11
    } head_op_e;

    // Control bundle sampled at each edge
    typedef struct packed {
        ctl_mode_e mode;
        logic      j;
        logic      kbar;
    } ctl_t;

    function automatic head_op_e head_decode(input logic j, input logic kbar);
        head_op_e op;
        unique case ({j, kbar})
            2'b00:   op = HEAD_CLR;
            2'b01:   op = HEAD_HOLD;
            2'b10:   op = HEAD_TGL;
            default: op = HEAD_SET;
        endcase
        return op;
    endfunction

    function automatic logic head_apply(input head_op_e op, input logic cur);
        logic nxt;
        unique case (op)
            HEAD_CLR:  nxt = 1'b0;
            HEAD_HOLD: nxt = cur;
            HEAD_TGL:  nxt = ~cur;
            default:   nxt = 1'b1;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/sr_jk_head.sv
module sr_jk_head
    import sr_jk_pkg::*;
(
    input  ctl_t ctl,
    input  logic cur,
    output logic nxt
);
    head_op_e op;

    always_comb begin
        op  = head_decode(ctl.j, ctl.kbar);
        nxt = head_apply(op, cur);
    end
endmodule

// File: rtl/sr_jk_next.sv
module sr_jk_next
    import sr_jk_pkg::*;
#(
    parameter int unsigned WIDTH = SR_WIDTH_DEF
) (
    input  ctl_mode_e        mode,
    input  logic             head_bit,
    input  logic [WIDTH-1:0] par_d,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    localparam int unsigned LAST = WIDTH - 1;

    // Stage 0 takes the J-K result when shifting
    always_comb begin
        nxt[0] = (mode == CTL_SHIFT) ? head_bit : par_d[0];
    end

    // Remaining stages take their predecessor when shifting
    for (genvar i = 1; i <= LAST; i++) begin : g_stage
        always_comb begin
            nxt[i] = (mode == CTL_SHIFT) ? cur[i-1] : par_d[i];
        end
    end
endmodule

// File: rtl/sr_jk_state.sv
module sr_jk_state
    import sr_jk_pkg::*;
#(
    parameter int unsigned WIDTH = SR_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sr_jk_shifter.sv
module sr_jk_shifter
    import sr_jk_pkg::*;
#(
    parameter int unsigned WIDTH = SR_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             shift_nload,
    input  logic             j_in,
    input  logic             kbar_in,
    input  logic [WIDTH-1:0] par_d,
    output logic [WIDTH-1:0] q,
    output logic             q_last_n
);
    localparam int unsigned LAST = WIDTH - 1;

    ctl_t             ctl;
    logic             head_nxt;
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] stage_d;

    always_comb begin
        ctl.mode = ctl_mode_e'(shift_nload);
        ctl.j    = j_in;
        ctl.kbar = kbar_in;
    end

    sr_jk_head u_head (
        .ctl (ctl),
        .cur (stage_q[0]),
        .nxt (head_nxt)
    );

    sr_jk_next #(.WIDTH(WIDTH)) u_next (
        .mode     (ctl.mode),
        .head_bit (head_nxt),
        .par_d    (par_d),
        .cur      (stage_q),
        .nxt      (stage_d)
    );

    sr_jk_state #(.WIDTH(WIDTH)) u_state (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (stage_d),
        .q     (stage_q)
    );

    assign q        = stage_q;
    assign q_last_n = ~stage_q[LAST];
endmodule

// File: rtl/sr_jk_shifter_chk.sv
module sr_jk_shifter_chk #(
    parameter int unsigned W = 4
) (
    input logic         clk,
    input logic         clr_n,
    input logic         shift_nload,
    input logic         j_in,
    input logic         kbar_in,
    input logic [W-1:0] par_d,
    input logic [W-1:0] q,
    input logic         q_last_n
);
    // R1
    clear_zero_chk: assert property (@(posedge clk)
        !clr_n |-> (q == '0));

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!shift_nload) |=> (q == $past(par_d)));

    // R3
    shift_move_chk: assert property (@(posedge clk) disable iff (!clr_n)
        shift_nload |=> (q[W-1:1] == $past(q[W-2:0])));

    // R4
    head_clear_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_nload && !j_in && !kbar_in) |=> !q[0]);

    // R5
    head_set_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_nload && j_in && kbar_in) |=> q[0]);

    // R6
    head_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_nload && !j_in && kbar_in) |=> $stable(q[0]));

    // R7
    head_toggle_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_nload && j_in && !kbar_in) |=> (q[0] != $past(q[0])));

    // R8
    last_inv_chk: assert property (@(posedge clk) disable iff (!clr_n)
        q_last_n == !q[W-1]);
endmodule

bind sr_jk_shifter sr_jk_shifter_chk #(.W(WIDTH)) u_chk (
    .clk         (clk),
    .clr_n       (clr_n),
    .shift_nload (shift_nload),
    .j_in        (j_in),
    .kbar_in     (kbar_in),
    .par_d       (par_d),
    .q           (q),
    .q_last_n    (q_last_n)
);

// File: tb/sr_jk_shifter_test.sv
module sr_jk_shifter_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         shift_nload = 1'b0;
    logic         j_in = 1'b0;
    logic         kbar_in = 1'b0;
    logic [W-1:0] par_d = '0;
    logic [W-1:0] q;
    logic         q_last_n;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] model = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sr_jk_shifter #(.WIDTH(W)) uut (
        .clk(clk), .clr_n(clr_n), .shift_nload(shift_nload),
        .j_in(j_in), .kbar_in(kbar_in), .par_d(par_d),
        .q(q), .q_last_n(q_last_n)
    );

    function automatic logic [W-1:0] ref_next(input logic [W-1:0] cur, input logic sh,
                                              input logic j, input logic kb,
                                              input logic [W-1:0] d);
        logic [W-1:0] r;
        logic h;
        if (!sh) return d;
        if (j && kb)        h = 1'b1;
        else if (!j && !kb) h = 1'b0;
        else if (j)         h = !cur[0];
        else                h = cur[0];
        r = {cur[W-2:0], h};
        return r;
    endfunction

    function automatic string tag_for(input logic sh, input logic j, input logic kb);
        if (!sh) return "R2";
        case ({j, kb})
            2'b00:   return "R4";
            2'b11:   return "R5";
            2'b01:   return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_inv();
        checks++;
        if (q_last_n !== ~model[W-1]) begin
            failures++;
            $display("FAIL R8 actual=%b expected=%b", q_last_n, ~model[W-1]);
        end
    endtask

    // Called at a falling edge; applies inputs, crosses one rising edge, checks at next falling edge
    task automatic step(input logic sh, input logic j, input logic kb, input logic [W-1:0] d,
                        input string tag);
        shift_nload = sh; j_in = j; kbar_in = kb; par_d = d;
        model = ref_next(model, sh, j, kb, d);
        @(posedge clk);
        @(negedge clk);
        check(tag, q, model);
        check_inv();
    endtask

    // Clear between edges, checked before and after an edge that would load a non-zero word
    task automatic mid_clear();
        #2 clr_n = 1'b0;
        shift_nload = 1'b0; par_d = 4'b1011; j_in = 1'b1; kbar_in = 1'b1;
        #1 check("R1", q, '0);
        model = '0;
        @(posedge clk);
        @(negedge clk);
        check("R1", q, '0);
        check_inv();
        clr_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5EED_0042));
        #2 check("R1", q, '0);
        @(negedge clk);
        check("R1", q, '0);
        clr_n = 1'b1;
        // R10: first edge after release loads normally
        step(1'b0, 1'b0, 1'b0, 4'b0110, "R10");
        // R2: serial inputs ignored while loading
        step(1'b0, 1'b1, 1'b0, 4'b1001, "R2");
        step(1'b0, 1'b1, 1'b1, 4'b0000, "R2");
        step(1'b0, 1'b1, 1'b1, 4'b1111, "R2");
        // R3 and R4: shift zeros in, par_d ignored
        step(1'b1, 1'b0, 1'b0, 4'b1010, "R4");
        step(1'b1, 1'b0, 1'b0, 4'b1010, "R3");
        // R5: set
        step(1'b1, 1'b1, 1'b1, 4'b0000, "R5");
        // R6: hold head while chain shifts
        step(1'b1, 1'b0, 1'b1, 4'b0000, "R6");
        step(1'b1, 1'b0, 1'b1, 4'b0000, "R6");
        // R7: toggle runs
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, 4'b0000, "R7");
        // R9: inputs wiggle between edges with no effect
        for (int i = 0; i < 4; i++) begin
            #1 par_d = W'($urandom); shift_nload = 1'($urandom);
            j_in = 1'($urandom); kbar_in = 1'($urandom);
            #1 check("R9", q, model);
            step(1'b0, 1'b0, 1'b0, 4'b1100, "R2");
        end
        // R1: clear mid-phase overrides load; R10: first edge after release shifts from zero
        mid_clear();
        step(1'b1, 1'b1, 1'b0, 4'b1111, "R10");
        step(1'b1, 1'b1, 1'b0, 4'b1111, "R7");
        // Random traffic with occasional clears and held J-K runs
        for (int n = 0; n < 400; n++) begin
            logic sh, j, kb;
            logic [W-1:0] d;
            if ($urandom_range(0, 39) == 0) begin
                mid_clear();
            end else begin
                sh = ($urandom_range(0, 3) != 0);
                j  = 1'($urandom);
                kb = 1'($urandom);
                d  = W'($urandom);
                for (int k = 0; k < int'($urandom_range(1, 3)); k++)
                    step(sh, j, kb, d, tag_for(sh, j, kb));
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule